// File: doc/BRIEF.md
# Memory refresh interval timer

This block paces refresh for a DRAM or SDRAM controller. An 8-bit up-counter advances at a rate set by a prescaler and is compared with a programmable 8-bit constant. When the counter matches the constant at an advance, the counter returns to zero and the block pulses a one-clock refresh request toward the command sequencer. The same match sets a compare flag, which can raise an interrupt. A tally of issued requests sets an overflow flag when it reaches a selectable limit.

Software reaches three 16-bit registers over a plain register bus: the control/status word, the counter and the compare constant. A write is taken only when its upper byte carries the key 8'hA5; the lower byte is then the new contents. Every bus write is a whole 16-bit word. The pins carry no data stream, so there is no valid/ready handshake and no back-pressure: the register bus completes every write in the cycle its strobe is high, and the refresh request is a single-cycle pulse that the sequencer must catch. The compare flag is cleared by a two-step rule: software writes 0 to it, then a CBR refresh completes. A manual reset restarts the prescaler and the request tally but keeps all three registers.

Top module: `rit_refresh_timer`

## Requirements
- R1: Power-on reset (por_n low) clears the control word, the counter and the compare constant to zero. rfsh_req, irq_cmatch and irq_ovf are then low.
- R2: A write whose upper byte is not 8'hA5 changes no register. Addresses are 0 (control), 1 (counter) and 2 (compare constant).
- R3: Bits 15..8 of every register read as zero.
- R4: The clock-select field (control bits 5..3) sets the advance interval: 0 stops the counter; codes 1..7 give 4, 16, 64, 256, 1024, 2048 and 4096 clocks. An accepted control write restarts the interval, so the first advance comes that many clocks after the write.
- R5: At an advance where the counter equals the constant, the counter goes to 0, the compare flag (control bit 7) sets, and rfsh_req is high for exactly one clock, all visible right after that edge.
- R6: Writing 1 to the compare flag has no effect. Writing 0 on its own does not clear it.
- R7: A set compare flag clears only when rfsh_done is seen with rfsh_en=1 and rmode_self=0 after a 0 has been written to the flag; a completion with rmode_self=1 or rfsh_en=0 leaves it set.
- R8: irq_cmatch is high exactly when the compare flag and the compare interrupt enable (control bit 6) are both 1.
- R9: The overflow flag (control bit 2) sets on the refresh request that brings the tally to 1024 (limit select, bit 0, = 0) or 512 (bit 0 = 1). irq_ovf is the flag ANDed with the overflow enable (bit 1). Writing 0 to bit 2 clears the flag; writing 1 does nothing.
- R10: A manual reset (mrst_n low) leaves the control word, counter and compare constant unchanged. It restarts the prescaler and zeroes the request tally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| mrst_n | input | 1 | Manual reset, synchronous, active low |
| bus_addr | input | 2 | Register select: 0 control, 1 counter, 2 compare constant |
| bus_wdata | input | 16 | Write word: key in the upper byte, data in the lower byte |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 16 | Read data for bus_addr, upper byte zero |
| rfsh_en | input | 1 | Refresh enabled in the controller |
| rmode_self | input | 1 | 1 = self-refresh mode, 0 = CBR refresh |
| rfsh_done | input | 1 | One-clock pulse when a refresh completes |
| rfsh_req | output | 1 | One-clock refresh request pulse |
| irq_cmatch | output | 1 | Compare-match interrupt |
| irq_ovf | output | 1 | Overflow interrupt |

## Verification
The assertions assume the compare constant is programmed before a nonzero clock select, that rfsh_done is a pulse from the sequencer and not a level, and that the shortest interval is four clocks, which keeps two requests from ever being back to back. The bench drives every input on the falling edge and changes the counter, constant and clock select only while the counter is stopped or right after a control write. A scoreboard queue holds the clock index of each request the bench expects. Those indices come from the interval and the constant, with the restart counted from the edge that takes the control write.

// File: rtl/rit_pkg.sv
package rit_pkg;

  localparam logic [7:0] WR_KEY = 8'hA5;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CNT  = 2'd1,
    SEL_COR  = 2'd2
  } reg_sel_e;

  typedef struct packed {
    logic       cmf;
    logic       cmie;
    logic [2:0] cks;
    logic       ovf;
    logic       ovie;
    logic       lmts;
  } ctrl_t;

  function automatic logic [3:0] div_shift(input logic [2:0] cks);
    case (cks)
      3'd1:    div_shift = 4'd2;
      3'd2:    div_shift = 4'd4;
      3'd3:    div_shift = 4'd6;
      3'd4:    div_shift = 4'd8;
      3'd5:    div_shift = 4'd10;
      3'd6:    div_shift = 4'd11;
      3'd7:    div_shift = 4'd12;
      default: div_shift = 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/rit_prescaler.sv
module rit_prescaler #(
  parameter int DIV_W = 12
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       restart,
  input  logic [2:0] cks,
  output logic       tick
);
  import rit_pkg::*;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  always_comb begin
    mask = ~({DIV_W{1'b1}} << div_shift(cks));
    tick = (cks != 3'd0) && ((div_q & mask) == mask);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       div_q <= '0;
    else if (restart) div_q <= '0;
    else              div_q <= div_q + 1'b1;
  end

  // Shortest interval is four clocks, so ticks never come back to back.
  p_tick_gap_r4: assert property (@(posedge clk) disable iff (!por_n)
    tick && !restart |=> !tick);

endmodule

// File: rtl/rit_ctrl_reg.sv
module rit_ctrl_reg (
  input  logic               clk,
  input  logic               por_n,
  input  logic               wr_acc,
  input  logic [7:0]         wr_low,
  input  logic               match_evt,
  input  logic               ovf_evt,
  input  logic               rfsh_done,
  input  logic               rfsh_en,
  input  logic               rmode_self,
  output rit_pkg::ctrl_t     ctrl
);
  import rit_pkg::*;

  logic armed_q;
  logic cbr_done;
  logic clr_cmf;

  assign cbr_done = rfsh_done && rfsh_en && !rmode_self;
  assign clr_cmf  = armed_q && cbr_done;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ctrl    <= '0;
      armed_q <= 1'b0;
    end else begin
      if (wr_acc) begin
        ctrl.cmie <= wr_low[6];
        ctrl.cks  <= wr_low[5:3];
        ctrl.ovie <= wr_low[1];
        ctrl.lmts <= wr_low[0];
      end
      if (match_evt)    ctrl.cmf <= 1'b1;
      else if (clr_cmf) ctrl.cmf <= 1'b0;

      if (clr_cmf || match_evt && !ctrl.cmf)   armed_q <= 1'b0;
      else if (wr_acc && !wr_low[7] && ctrl.cmf) armed_q <= 1'b1;

      if (ovf_evt)                      ctrl.ovf <= 1'b1;
      else if (wr_acc && !wr_low[2])    ctrl.ovf <= 1'b0;
    end
  end

  // A set flag survives any cycle without a refresh completion.
  p_cmf_hold_r6: assert property (@(posedge clk) disable iff (!por_n)
    ctrl.cmf && !rfsh_done |=> ctrl.cmf);

  // A completion that is not a CBR refresh never clears the flag.
  p_cmf_mode_r7: assert property (@(posedge clk) disable iff (!por_n)
    ctrl.cmf && rfsh_done && (!rfsh_en || rmode_self) |=> ctrl.cmf);

  // Overflow flag survives writes of 1.
  p_ovf_hold_r9: assert property (@(posedge clk) disable iff (!por_n)
    ctrl.ovf && !(wr_acc && !wr_low[2]) |=> ctrl.ovf);

endmodule

// File: rtl/rit_refresh_tally.sv
module rit_refresh_tally #(
  parameter int LIM_LO = 1024,
  parameter int LIM_HI = 512
) (
  input  logic clk,
  input  logic por_n,
  input  logic mrst_n,
  input  logic match_evt,
  input  logic lmts,
  output logic ovf_evt
);
  localparam int CW = $clog2(LIM_LO);
  localparam logic [CW-1:0] LAST_LO = CW'(LIM_LO - 1);
  localparam logic [CW-1:0] LAST_HI = CW'(LIM_HI - 1);

  logic [CW-1:0] tally_q;
  logic [CW-1:0] last;

  assign last    = lmts ? LAST_HI : LAST_LO;
  assign ovf_evt = match_evt && (tally_q >= last);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)         tally_q <= '0;
    else if (!mrst_n)   tally_q <= '0;
    else if (ovf_evt)   tally_q <= '0;
    else if (match_evt) tally_q <= tally_q + 1'b1;
  end

  p_tally_wrap_r9: assert property (@(posedge clk) disable iff (!por_n)
    ovf_evt |=> tally_q == '0);

endmodule

// File: rtl/rit_refresh_timer.sv
module rit_refresh_timer #(
  parameter int CNT_W  = 8,
  parameter int DIV_W  = 12,
  parameter int LIM_LO = 1024,
  parameter int LIM_HI = 512
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        mrst_n,
  input  logic [1:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  input  logic        bus_we,
  output logic [15:0] bus_rdata,
  input  logic        rfsh_en,
  input  logic        rmode_self,
  input  logic        rfsh_done,
  output logic        rfsh_req,
  output logic        irq_cmatch,
  output logic        irq_ovf
);
  import rit_pkg::*;

  logic             key_ok;
  logic             wr_ctrl, wr_cnt, wr_cor;
  logic             tick, match_evt, ovf_evt;
  logic [CNT_W-1:0] cnt_q, cor_q;
  ctrl_t            ctrl;

  assign key_ok  = bus_wdata[15:8] == WR_KEY;
  assign wr_ctrl = bus_we && key_ok && (bus_addr == SEL_CTRL);
  assign wr_cnt  = bus_we && key_ok && (bus_addr == SEL_CNT);
  assign wr_cor  = bus_we && key_ok && (bus_addr == SEL_COR);

  rit_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk     (clk),
    .por_n   (por_n),
    .restart (wr_ctrl || !mrst_n),
    .cks     (ctrl.cks),
    .tick    (tick)
  );

  assign match_evt = tick && (cnt_q == cor_q);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q    <= '0;
      cor_q    <= '0;
      rfsh_req <= 1'b0;
    end else begin
      if (wr_cnt)    cnt_q <= bus_wdata[CNT_W-1:0];
      else if (tick) cnt_q <= match_evt ? '0 : cnt_q + 1'b1;
      if (wr_cor)    cor_q <= bus_wdata[CNT_W-1:0];
      rfsh_req <= match_evt;
    end
  end

  rit_ctrl_reg u_ctrl (
    .clk        (clk),
    .por_n      (por_n),
    .wr_acc     (wr_ctrl),
    .wr_low     (bus_wdata[7:0]),
    .match_evt  (match_evt),
    .ovf_evt    (ovf_evt),
    .rfsh_done  (rfsh_done),
    .rfsh_en    (rfsh_en),
    .rmode_self (rmode_self),
    .ctrl       (ctrl)
  );

  rit_refresh_tally #(.LIM_LO(LIM_LO), .LIM_HI(LIM_HI)) u_tally (
    .clk       (clk),
    .por_n     (por_n),
    .mrst_n    (mrst_n),
    .match_evt (match_evt),
    .lmts      (ctrl.lmts),
    .ovf_evt   (ovf_evt)
  );

  assign irq_cmatch = ctrl.cmf && ctrl.cmie;
  assign irq_ovf    = ctrl.ovf && ctrl.ovie;

  always_comb begin
    case (bus_addr)
      SEL_CTRL: bus_rdata = {8'h00, ctrl};
      SEL_CNT:  bus_rdata = 16'(cnt_q);
      SEL_COR:  bus_rdata = 16'(cor_q);
      default:  bus_rdata = 16'h0000;
    endcase
  end

  p_key_r2: assert property (@(posedge clk) disable iff (!por_n)
    bus_we && !key_ok |=> $stable(cor_q) && $stable(ctrl.cks) && $stable(ctrl.cmie));

  p_stop_r4: assert property (@(posedge clk) disable iff (!por_n)
    ctrl.cks == 3'd0 |-> !tick);

  p_cnt_step_r4: assert property (@(posedge clk) disable iff (!por_n)
    tick && (cnt_q != cor_q) && !wr_cnt |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

  p_req_pulse_r5: assert property (@(posedge clk) disable iff (!por_n)
    rfsh_req |=> !rfsh_req);

  p_match_zero_r5: assert property (@(posedge clk) disable iff (!por_n)
    rfsh_req && !$past(wr_cnt) |-> cnt_q == '0 && ctrl.cmf);

  p_mrst_keep_r10: assert property (@(posedge clk) disable iff (!por_n)
    !mrst_n && !bus_we |=> $stable(cor_q) && $stable(ctrl.cks) && $stable(ctrl.lmts));

endmodule

// File: tb/rit_refresh_timer_tb_top.sv
module rit_refresh_timer_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        mrst_n = 1'b1;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'h0000;
  logic        bus_we = 1'b0;
  logic [15:0] bus_rdata;
  logic        rfsh_en = 1'b1;
  logic        rmode_self = 1'b0;
  logic        rfsh_done = 1'b0;
  logic        rfsh_req, irq_cmatch, irq_ovf;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rit_refresh_timer dut_i (
    .clk(clk), .por_n(por_n), .mrst_n(mrst_n),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata),
    .rfsh_en(rfsh_en), .rmode_self(rmode_self), .rfsh_done(rfsh_done),
    .rfsh_req(rfsh_req), .irq_cmatch(irq_cmatch), .irq_ovf(irq_ovf)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [15:0] d, output int at);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    at = cyc;
  endtask

  task automatic reg_rd(input logic [1:0] a, output int v);
    bus_addr = a;
    #1 v = int'(bus_rdata);
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic pulse_done(input logic en, input logic self_mode);
    @(negedge clk);
    rfsh_en = en; rmode_self = self_mode; rfsh_done = 1'b1;
    @(negedge clk);
    rfsh_done = 1'b0; rfsh_en = 1'b1; rmode_self = 1'b0;
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // Scoreboard monitor: every request pops the expected clock index.
  always @(negedge clk) begin
    if (por_n && rfsh_req) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R5 unexpected rfsh_req actual=%0d expected=none", cyc);
      end else begin
        check("R5 request timing", cyc, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=finished", cyc);
    summary();
  end

  initial begin
    int w, v, v0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    reg_rd(2'd0, v); check("R1 ctrl", v, 0);
    reg_rd(2'd1, v); check("R1 cnt", v, 0);
    reg_rd(2'd2, v); check("R1 cor", v, 0);
    check("R1 outputs", {rfsh_req, irq_cmatch, irq_ovf}, 0);

    // R3 upper byte reads zero, R2 key protection
    reg_wr(2'd2, 16'hA53C, w); reg_rd(2'd2, v); check("R3 cor readback", v, 16'h003C);
    reg_wr(2'd2, 16'h5A11, w); reg_rd(2'd2, v); check("R2 cor bad key", v, 16'h003C);
    reg_wr(2'd0, 16'h0038, w); reg_rd(2'd0, v); check("R2 ctrl bad key", v, 0);
    reg_wr(2'd1, 16'h1207, w); reg_rd(2'd1, v); check("R2 cnt bad key", v, 0);

    // R4 rate: code 3 = 64 clocks
    reg_wr(2'd2, 16'hA5FF, w);
    reg_wr(2'd1, 16'hA500, w);
    reg_wr(2'd0, 16'hA518, w);
    wait_until(w + 191); reg_rd(2'd1, v); check("R4 before third advance", v, 2);
    wait_until(w + 192); reg_rd(2'd1, v); check("R4 third advance", v, 3);
    reg_wr(2'd0, 16'hA500, w);
    reg_rd(2'd1, v0);
    repeat (80) @(negedge clk);
    reg_rd(2'd1, v); check("R4 code 0 stops", v, v0);

    // R5 scoreboard: constant 2, code 1 -> match every 12 clocks
    reg_wr(2'd2, 16'hA502, w);
    reg_wr(2'd1, 16'hA500, w);
    reg_wr(2'd0, 16'hA5C8, w);
    for (int k = 1; k <= 3; k++) exp_q.push_back(w + 12 * k);
    wait_until(w + 11);
    reg_rd(2'd0, v); check("R6 write 1 to clear flag", v, 16'h0048);
    check("R8 irq low before match", irq_cmatch, 0);
    wait_until(w + 12);
    reg_rd(2'd0, v); check("R5 flag set on match", v, 16'h00C8);
    reg_rd(2'd1, v); check("R5 counter zero after match", v, 0);
    check("R8 irq on match", irq_cmatch, 1);
    wait_until(w + 37);
    reg_wr(2'd0, 16'hA5C0, w);

    // R6 / R7 / R8 clear sequence
    pulse_done(1'b1, 1'b0);
    reg_rd(2'd0, v); check("R6 no clear without zero write", v, 16'h00C0);
    reg_wr(2'd0, 16'hA540, w);
    reg_rd(2'd0, v); check("R6 zero write alone", v, 16'h00C0);
    pulse_done(1'b1, 1'b1);
    reg_rd(2'd0, v); check("R7 self mode no clear", v, 16'h00C0);
    pulse_done(1'b0, 1'b0);
    reg_rd(2'd0, v); check("R7 refresh disabled no clear", v, 16'h00C0);
    reg_wr(2'd0, 16'hA500, w);
    reg_rd(2'd0, v); check("R8 masked ctrl", v, 16'h0080);
    check("R8 irq masked", irq_cmatch, 0);
    pulse_done(1'b1, 1'b0);
    reg_rd(2'd0, v); check("R7 CBR clears", v, 0);

    // R10 manual reset keeps registers
    reg_wr(2'd0, 16'hA503, w);
    reg_wr(2'd2, 16'hA500, w);
    reg_wr(2'd1, 16'hA577, w);
    @(negedge clk); mrst_n = 1'b0;
    @(negedge clk); mrst_n = 1'b1;
    reg_rd(2'd0, v); check("R10 ctrl kept", v, 16'h0003);
    reg_rd(2'd1, v); check("R10 cnt kept", v, 16'h0077);
    reg_rd(2'd2, v); check("R10 cor kept", v, 0);

    // R9 overflow at 512 requests (limit select 1)
    reg_wr(2'd1, 16'hA500, w);
    reg_wr(2'd0, 16'hA50B, w);
    for (int k = 1; k <= 512; k++) exp_q.push_back(w + 4 * k);
    wait_until(w + 2044);
    reg_rd(2'd0, v); check("R9 no overflow at 511", v, 16'h008B);
    check("R9 irq low at 511", irq_ovf, 0);
    wait_until(w + 2048);
    reg_rd(2'd0, v); check("R9 overflow at 512", v, 16'h008F);
    check("R9 irq at 512", irq_ovf, 1);
    wait_until(w + 2049);
    reg_wr(2'd0, 16'hA503, w);
    reg_rd(2'd0, v); check("R9 write 0 clears overflow", v, 16'h0083);
    check("R9 irq cleared", irq_ovf, 0);

    repeat (20) @(negedge clk);
    check("R5 all requests seen", exp_q.size(), 0);
    summary();
  end

endmodule